// File: doc/BRIEF.md
# Prefetching SPI Flash Port Controller

This block lets a byte-wide CPU bus run an SPI flash device as bus master. Four addresses form the CPU side. A write to the transmit address sends one byte out on the serial line. A read of the prefetch address returns the byte that was captured last and, in the same access, starts eight serial clocks that capture the next byte. A read of the plain receive address returns the captured byte and produces no serial clocks. The fourth address holds the control bits on write and the status bits on read.

The read path has one byte of lag. A read burst therefore starts with a prefetch read whose data is stale and is thrown away. Further prefetch reads follow, and a plain receive read collects the last byte. The CPU controls chip select through a control bit, so it can frame commands that span many bytes. Before each transmit write or prefetch read, the CPU polls the busy bit. Clock polarity follows SPI mode 0 or mode 3. The serial clock is the system clock divided by an even ratio from 4 to 16. With a 50 MHz system clock this gives serial rates of about 3 MHz to 12.5 MHz.

Top module: `spi_prefetch_port`

## Requirements
- R1: After reset: spi_cs_n is 1, spi_sclk is 0, spi_mosi is 0, busy is 0, cpu_rdata is 0, and the status word is 0.
- R2: A write to address 0 while idle shifts cpu_wdata out on spi_mosi, most significant bit first, with exactly eight rising spi_sclk edges. spi_mosi changes only at a falling edge or at the start of the transfer. It never changes while spi_sclk is high.
- R3: A read of address 1 while idle puts the latched byte on cpu_rdata in the cycle after the read. It also starts an eight-clock transfer with spi_mosi held at 1.
- R4: A read of address 2 returns the latched byte on cpu_rdata in the next cycle. It produces no spi_sclk edge and leaves busy low.
- R5: Every transfer, transmit or receive, samples spi_miso on each rising spi_sclk edge, most significant bit first. The latched byte is replaced with the result when the transfer ends.
- R6: busy rises in the cycle after an accepted access and stays high for exactly 16*H cycles. H is 2 plus the 3-bit divider field, capped at 8, so the spi_sclk period is 2*H system clocks.
- R7: Control bit 0 sets the idle level of spi_sclk: 0 selects mode 0 (idle low) and 1 selects mode 3 (idle high). The new level appears one cycle after the control write. In mode 3 a transfer opens with a falling edge.
- R8: A read of address 3 returns status: bit 0 busy, bit 1 overrun, bit 2 mode, bit 3 chip-select enable, bits 6:4 divider field, bit 7 zero.
- R9: A transmit write or prefetch read that arrives while busy is ignored. No transfer starts, busy is not extended, and the latched byte is unchanged. The access sets the sticky overrun bit. The overrun bit clears only when a control write has bit 7 set.
- R10: spi_cs_n is the inverse of control bit 1. It updates one cycle after the control write. Control bits 4:2 form the divider field.
- R11: A burst of one stale prefetch read, then prefetch reads, then one plain read returns the flash bytes in the order the flash sent them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | CPU write strobe, one cycle |
| cpu_rd | input | 1 | CPU read strobe, one cycle |
| cpu_addr | input | 2 | 0 transmit, 1 prefetch receive, 2 plain receive, 3 control/status |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Registered read data, valid the cycle after cpu_rd |
| busy | output | 1 | High while a byte transfer runs |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
Some internal faults corrupt the state of a transfer: the phase counter, a divider count, or the latched half period. Such a fault changes how long busy stays high. The per-cycle model catches this at the first cycle where the busy falling edge should have been. A broken transmit shift register shows up at the end of that byte, as the wrong captured spi_mosi value or a count of rising edges other than eight. A fault in the receive capture or the latch stays hidden until the next read of address 1 or 2 returns the wrong byte. A fault in the mode or chip-select register shows on the idle spi_sclk level or on spi_cs_n in the cycle after the control write.

// File: rtl/spi_pf_pkg.sv
package spi_pf_pkg;
  typedef enum logic [1:0] {
    PORT_TX  = 2'd0,
    PORT_PRX = 2'd1,
    PORT_RX  = 2'd2,
    PORT_CSR = 2'd3
  } port_e;

  localparam int CSR_MODE_BIT = 0;
  localparam int CSR_CS_BIT   = 1;
  localparam int CSR_SEL_LSB  = 2;
  localparam int CSR_CLR_BIT  = 7;
endpackage

// File: rtl/spi_pf_regs.sv
module spi_pf_regs
  import spi_pf_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int SEL_W    = 3,
  parameter int MIN_HALF = 2,
  parameter int MAX_HALF = 8,
  parameter int HALF_W   = $clog2(MAX_HALF + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [1:0]        cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              eng_busy,
  input  logic [DATA_W-1:0] rx_byte,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              start,
  output logic [DATA_W-1:0] start_data,
  output logic              mode3,
  output logic              cs_n,
  output logic              ovr,
  output logic [HALF_W-1:0] half
);
  localparam int SEL_CAP = MAX_HALF - MIN_HALF;

  port_e             port;
  logic              access;
  logic              csr_wr;
  logic              cs_act;
  logic [SEL_W-1:0]  sel_q;
  logic [DATA_W-1:0] status;
  logic              unused_wdata;

  assign port         = port_e'(cpu_addr);
  assign access       = (cpu_wr && port == PORT_TX) || (cpu_rd && port == PORT_PRX);
  assign csr_wr       = cpu_wr && port == PORT_CSR;
  assign start        = access && !eng_busy;
  assign start_data   = (cpu_wr && port == PORT_TX) ? cpu_wdata : '1;
  assign status       = DATA_W'({sel_q, cs_act, mode3, ovr, eng_busy});
  assign cs_n         = !cs_act;
  assign unused_wdata = ^cpu_wdata[CSR_CLR_BIT-1:CSR_SEL_LSB+SEL_W];

  always_comb begin
    if (int'(sel_q) > SEL_CAP) half = HALF_W'(MAX_HALF);
    else                       half = HALF_W'(MIN_HALF + int'(sel_q));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode3  <= 1'b0;
      cs_act <= 1'b0;
      sel_q  <= '0;
    end else if (csr_wr) begin
      mode3  <= cpu_wdata[CSR_MODE_BIT];
      cs_act <= cpu_wdata[CSR_CS_BIT];
      sel_q  <= cpu_wdata[CSR_SEL_LSB +: SEL_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                    ovr <= 1'b0;
    else if (csr_wr && cpu_wdata[CSR_CLR_BIT])  ovr <= 1'b0;
    else if (access && eng_busy)                ovr <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_rdata <= '0;
    end else if (cpu_rd) begin
      case (port)
        PORT_PRX, PORT_RX: cpu_rdata <= rx_byte;
        PORT_CSR:          cpu_rdata <= status;
        default:           cpu_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/spi_pf_engine.sv
module spi_pf_engine #(
  parameter int DATA_W = 8,
  parameter int HALF_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] start_data,
  input  logic              mode3,
  input  logic [HALF_W-1:0] half,
  input  logic              miso,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int PHASES  = 2 * DATA_W;
  localparam int PH_W    = $clog2(PHASES);
  localparam int LAST_PH = PHASES - 1;

  logic [PH_W-1:0]   ph;
  logic [HALF_W-1:0] cnt;
  logic [HALF_W-1:0] half_q;
  logic [DATA_W-1:0] tx_sh;
  logic [DATA_W-1:0] rx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      sclk    <= 1'b0;
      mosi    <= 1'b0;
      ph      <= '0;
      cnt     <= '0;
      half_q  <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      rx_byte <= '0;
    end else if (!busy) begin
      sclk <= mode3;
      if (start) begin
        busy   <= 1'b1;
        sclk   <= 1'b0;
        mosi   <= start_data[DATA_W-1];
        tx_sh  <= {start_data[DATA_W-2:0], 1'b0};
        ph     <= '0;
        cnt    <= '0;
        half_q <= half;
      end
    end else if (cnt + 1'b1 == half_q) begin
      cnt <= '0;
      if (ph == PH_W'(LAST_PH)) begin
        busy    <= 1'b0;
        sclk    <= mode3;
        rx_byte <= rx_sh;
      end else begin
        ph   <= ph + 1'b1;
        sclk <= ~sclk;
        if (!ph[0]) begin
          rx_sh <= {rx_sh[DATA_W-2:0], miso};
        end else begin
          mosi  <= tx_sh[DATA_W-1];
          tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
        end
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spi_prefetch_port.sv
module spi_prefetch_port #(
  parameter int DATA_W   = 8,
  parameter int SEL_W    = 3,
  parameter int MIN_HALF = 2,
  parameter int MAX_HALF = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [1:0]        cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              busy,
  output logic              spi_cs_n,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int HALF_W = $clog2(MAX_HALF + 1);

  logic              start;
  logic [DATA_W-1:0] start_data;
  logic              mode3;
  logic              ovr;
  logic [HALF_W-1:0] half;
  logic [DATA_W-1:0] rx_byte;

  spi_pf_regs #(
    .DATA_W(DATA_W), .SEL_W(SEL_W), .MIN_HALF(MIN_HALF),
    .MAX_HALF(MAX_HALF), .HALF_W(HALF_W)
  ) u_regs (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .eng_busy(busy),
    .rx_byte(rx_byte), .cpu_rdata(cpu_rdata), .start(start),
    .start_data(start_data), .mode3(mode3), .cs_n(spi_cs_n),
    .ovr(ovr), .half(half)
  );

  spi_pf_engine #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_engine (
    .clk(clk), .rst(rst), .start(start), .start_data(start_data),
    .mode3(mode3), .half(half), .miso(spi_miso), .busy(busy),
    .sclk(spi_sclk), .mosi(spi_mosi), .rx_byte(rx_byte)
  );
endmodule

// File: rtl/spi_pf_checker.sv
module spi_pf_checker (
  input logic       clk,
  input logic       rst,
  input logic       cpu_wr,
  input logic       cpu_rd,
  input logic [1:0] cpu_addr,
  input logic       wdata_cs,
  input logic       busy,
  input logic       mode3,
  input logic       ovr,
  input logic       sclk,
  input logic       mosi,
  input logic       cs_n
);
  logic ok_q;
  always_ff @(posedge clk) begin
    if (rst) ok_q <= 1'b0;
    else     ok_q <= 1'b1;
  end

  assert_idle_level_R7: assert property (@(posedge clk) disable iff (rst)
    ok_q && !busy && !$past(busy) |-> sclk == $past(mode3));

  assert_mosi_hold_R2: assert property (@(posedge clk) disable iff (rst)
    ok_q && sclk && $past(sclk) |-> $stable(mosi));

  assert_prefetch_start_R3: assert property (@(posedge clk) disable iff (rst)
    ok_q && !busy && cpu_rd && cpu_addr == 2'd1 |=> busy);

  assert_plain_no_clock_R4: assert property (@(posedge clk) disable iff (rst)
    ok_q && !busy && cpu_rd && cpu_addr == 2'd2 |=> !busy && $stable(sclk));

  assert_overrun_set_R9: assert property (@(posedge clk) disable iff (rst)
    ok_q && busy && cpu_wr && cpu_addr == 2'd0 |=> ovr);

  assert_cs_follow_R10: assert property (@(posedge clk) disable iff (rst)
    ok_q && cpu_wr && cpu_addr == 2'd3 |=> cs_n == !$past(wdata_cs));
endmodule

bind spi_prefetch_port spi_pf_checker u_chk (
  .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
  .cpu_addr(cpu_addr), .wdata_cs(cpu_wdata[1]), .busy(busy),
  .mode3(mode3), .ovr(ovr), .sclk(spi_sclk), .mosi(spi_mosi),
  .cs_n(spi_cs_n)
);

// File: tb/spi_prefetch_port_bench.sv
module spi_prefetch_port_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst = 1'b1;
  logic       cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [1:0] cpu_addr = 2'd0;
  logic [7:0] cpu_wdata = 8'd0;
  logic [7:0] cpu_rdata;
  logic       busy, spi_cs_n, spi_sclk, spi_mosi;
  logic       spi_miso = 1'b1;

  spi_prefetch_port u_spi_prefetch_port (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .busy(busy), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int checks = 0;
  int errors = 0;

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference model
  int         bcnt = 0;
  bit         mode_m = 0, mode_d = 0, cs_m = 0, ovr_m = 0;
  int         sel_m = 0;
  logic [7:0] latch_m = 0, cur_slave = 0, cur_tx = 0, cap = 0;
  bit         new_xfer = 0, sclk_prev = 0;
  int         rises = 0, bitidx = 0;
  logic [7:0] slave_q[$];

  function automatic int half_of(input int s);
    return (s > 6) ? 8 : s + 2;
  endfunction

  function automatic int status_exp();
    return (sel_m << 4) | (int'(cs_m) << 3) | (int'(mode_m) << 2) |
           (int'(ovr_m) << 1) | int'(bcnt > 0);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      bcnt = 0; mode_m = 0; mode_d = 0; cs_m = 0; ovr_m = 0;
      sel_m = 0; latch_m = 0;
    end else begin
      bit acc;
      mode_d = mode_m;
      acc = (cpu_wr && cpu_addr == 2'd0) || (cpu_rd && cpu_addr == 2'd1);
      if (cpu_wr && cpu_addr == 2'd3) begin
        mode_m = cpu_wdata[0];
        cs_m   = cpu_wdata[1];
        sel_m  = int'(cpu_wdata[4:2]);
        if (cpu_wdata[7]) ovr_m = 0;
      end
      if (bcnt > 0) begin
        if (acc) ovr_m = 1;
        bcnt--;
        if (bcnt == 0) begin
          latch_m = cur_slave;
          check_eq("R2", "mosi byte", cap, cur_tx);
          check_eq("R2", "rising edges", rises, 8);
        end
      end else if (acc) begin
        bcnt      = 16 * half_of(sel_m);
        cur_tx    = (cpu_wr && cpu_addr == 2'd0) ? cpu_wdata : 8'hFF;
        cur_slave = (slave_q.size() > 0) ? slave_q.pop_front() : 8'h00;
        new_xfer  = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check_eq("R6", "busy", busy, int'(bcnt > 0));
      check_eq("R10", "cs_n", spi_cs_n, int'(!cs_m));
      if (bcnt == 0) check_eq("R7", "idle sclk", spi_sclk, mode_d);
      if (new_xfer) begin
        new_xfer = 0; rises = 0; bitidx = 0; cap = 0;
        spi_miso = cur_slave[7];
      end else if (spi_sclk && !sclk_prev && bcnt > 0) begin
        cap = {cap[6:0], spi_mosi};
        rises++;
        bitidx++;
        spi_miso = (bitidx < 8) ? cur_slave[7 - bitidx] : 1'b1;
      end
      sclk_prev = spi_sclk;
    end
  end

  task automatic cpu_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic cpu_read(input logic [1:0] a, input int exp, input string req);
    @(negedge clk);
    cpu_rd = 1'b1; cpu_addr = a;
    @(negedge clk);
    cpu_rd = 1'b0;
    check_eq(req, "rdata", cpu_rdata, exp);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check_eq("R1", "cs_n", spi_cs_n, 1);
    check_eq("R1", "sclk", spi_sclk, 0);
    check_eq("R1", "mosi", spi_mosi, 0);
    check_eq("R1", "busy", busy, 0);
    check_eq("R1", "rdata", cpu_rdata, 0);
    cpu_read(2'd3, 0, "R1");

    // Mode 0, fastest divider, chip select on
    cpu_write(2'd3, 8'b0000_0010);
    check_eq("R10", "cs_n low", spi_cs_n, 0);
    slave_q.push_back(8'h4B);
    cpu_write(2'd0, 8'hA5);
    cpu_read(2'd3, status_exp(), "R8");
    wait_idle();
    cpu_read(2'd2, 8'h4B, "R5");
    cpu_read(2'd2, 8'h4B, "R4");

    // R11 burst in mode 0
    slave_q.push_back(8'h3C); slave_q.push_back(8'h96); slave_q.push_back(8'hE1);
    cpu_read(2'd1, 8'h4B, "R3");
    wait_idle();
    cpu_read(2'd1, 8'h3C, "R11");
    wait_idle();
    cpu_read(2'd1, 8'h96, "R11");
    wait_idle();
    cpu_read(2'd2, 8'hE1, "R11");

    // Mode 3, divider field 6
    cpu_write(2'd3, 8'b0001_1011);
    @(negedge clk);
    check_eq("R7", "mode3 idle high", spi_sclk, 1);
    cpu_read(2'd3, status_exp(), "R8");
    slave_q.push_back(8'h81);
    cpu_write(2'd0, 8'h5A);
    check_eq("R7", "mode3 opens low", spi_sclk, 0);
    wait_idle();
    cpu_read(2'd2, 8'h81, "R5");
    slave_q.push_back(8'h7E); slave_q.push_back(8'h18);
    cpu_read(2'd1, 8'h81, "R3");
    wait_idle();
    cpu_read(2'd1, 8'h7E, "R11");
    wait_idle();
    cpu_read(2'd2, 8'h18, "R11");

    // Divider field 7 caps at the slowest ratio, mode 0
    cpu_write(2'd3, 8'b0001_1110);
    slave_q.push_back(8'hC3);
    cpu_write(2'd0, 8'h0F);
    wait_idle();
    cpu_read(2'd2, 8'hC3, "R6");

    // R9 overrun
    slave_q.push_back(8'h99);
    slave_q.push_back(8'h55);
    cpu_write(2'd0, 8'h33);
    cpu_write(2'd0, 8'hCC);
    cpu_read(2'd1, 8'hC3, "R9");
    cpu_read(2'd2, 8'hC3, "R9");
    wait_idle();
    cpu_read(2'd3, status_exp(), "R9");
    check_eq("R9", "overrun flag", ovr_m, 1);
    cpu_read(2'd2, 8'h99, "R9");
    cpu_write(2'd3, 8'b1001_1110);
    cpu_read(2'd3, status_exp(), "R9");
    check_eq("R9", "queue left", slave_q.size(), 1);

    // Release chip select, back to mode 0
    cpu_write(2'd3, 8'b0000_0000);
    check_eq("R10", "cs_n high", spi_cs_n, 1);
    repeat (3) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule